// File: doc/BRIEF.md
# Quadrature Position Counter with Wrap Cascade

This block turns two quadrature channels (A and B) into a 16-bit signed-free position count. The channels are assumed to be already cleaned of noise. They are first brought into the clock domain through a short flop chain. Each sampled change is then decoded at four counts per quadrature cycle. Every accepted step moves the position counter by one. It also emits a one-clock count pulse with a direction level, so that a counter outside the block can follow along. When the internal counter wraps past either end of its range, a one-clock cascade pulse is raised in the same cycle. Outside logic uses this pulse to extend the position to any width it needs.

A host reads the position over an 8-bit bus through an active-low select and an active-low output enable. A holding register copies the counter on every falling clock edge. When a read begins, that register freezes so that the two bytes form one coherent value, while the counter itself keeps running. The freeze ends once the host has read the low byte and lifted the output enable.

Top module: `quad_cascade_counter`

## Requirements
- R1: Each valid step moves the count by one. Number the sampled (A,B) codes in the phase order 00, 10, 11, 01, with A as the first digit. A move to the next code in this order counts up. A move to the previous code counts down.
- R2: Counting up from FFFFh gives 0000h, and counting down from 0000h gives FFFFh.
- R3: `cas_pulse` is high for exactly the one clock in which the counter wraps in either direction. In that clock `cnt_pulse` is also high. At all other times `cas_pulse` is low.
- R4: Every accepted step gives exactly one clock of `cnt_pulse`, with `cnt_up` at 1 for an up step and 0 for a down step.
- R5: A change of both A and B between successive samples is ignored. It produces no pulse and leaves the count unchanged.
- R6: When `sel_n` and `oe_n` are both 0 at a falling clock edge, the holding register captures the count at that edge and then freezes. It stays frozen while the counter goes on counting.
- R7: With `oe_n` at 0, `data_out` shows bits 15:8 of the holding register when `sel_n` is 0, and bits 7:0 when `sel_n` is 1. With `oe_n` at 1, `data_out` is 00h.
- R8: The freeze ends at the first falling edge with `oe_n` at 1 that follows a low-byte read (`oe_n` 0, `sel_n` 1) made during the freeze. From then on the register tracks the counter again.
- R9: After reset the count and the holding register are 0000h, and `cnt_pulse`, `cas_pulse` and `cnt_up` are 0.
- R10: An input change made after a rising edge shows up in `cnt_pulse` and in the count after the third rising edge that follows. It does not appear after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the counter uses the rising edge and the holding register the falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ch_a | input | 1 | Quadrature channel A, asynchronous |
| ch_b | input | 1 | Quadrature channel B, asynchronous |
| sel_n | input | 1 | Byte select: 0 selects the high byte, 1 selects the low byte |
| oe_n | input | 1 | Output enable, active low; going low with `sel_n` low starts a read |
| data_out | output | 8 | Read data byte |
| cnt_pulse | output | 1 | One-clock pulse per accepted step |
| cnt_up | output | 1 | Direction of the most recent step, 1 = up |
| cas_pulse | output | 1 | One-clock pulse when the counter wraps |

## Verification
A counter wrap and the start of a host read can fall in the same clock. The rising edge that rolls the counter over is followed by the falling edge that freezes the holding register. The bench times a single step so that the read request is raised just after the wrapping edge. The frozen value must then be the wrapped value, and the queued cascade pulse must still be seen. In a second case the request is raised one clock earlier, and the pre-wrap value FFFFh must be held instead.

// File: rtl/qc_pkg.sv
package qc_pkg;

   typedef enum logic [1:0] {
      QS_IDLE = 2'd0,
      QS_UP   = 2'd1,
      QS_BAD  = 2'd2,
      QS_DOWN = 2'd3
   } qstep_e;

   // Map the sampled {A,B} code onto its position in the phase cycle
   // 00 -> 0, 10 -> 1, 11 -> 2, 01 -> 3.
   function automatic logic [1:0] phase_of(input logic [1:0] ab);
      return {ab[0], ab[1] ^ ab[0]};
   endfunction

endpackage

// File: rtl/qc_sync.sv
module qc_sync #(
   parameter int STAGES = 2,
   parameter int W      = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("qc_sync needs at least two stages");
   end

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/qc_decoder.sv
module qc_decoder
   import qc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] ab,
   output qstep_e     step
);

   logic [1:0] prev_q;
   logic [1:0] delta;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 2'b00;
      else        prev_q <= ab;
   end

   assign delta = phase_of(ab) - phase_of(prev_q);

   always_comb begin
      unique case (delta)
         2'd1:    step = QS_UP;
         2'd3:    step = QS_DOWN;
         2'd2:    step = QS_BAD;
         default: step = QS_IDLE;
      endcase
   end

endmodule

// File: rtl/qc_position.sv
module qc_position
   import qc_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  qstep_e       step,
   output logic [W-1:0] count,
   output logic         cnt_pulse,
   output logic         cnt_up,
   output logic         cas_pulse
);

   localparam logic [W-1:0] TOP = {W{1'b1}};

   logic going_up, going_dn;

   assign going_up = (step == QS_UP);
   assign going_dn = (step == QS_DOWN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count     <= '0;
         cnt_pulse <= 1'b0;
         cnt_up    <= 1'b0;
         cas_pulse <= 1'b0;
      end else begin
         cnt_pulse <= going_up | going_dn;
         cas_pulse <= (going_up && count == TOP) || (going_dn && count == '0);
         if (going_up) begin
            count  <= count + 1'b1;
            cnt_up <= 1'b1;
         end else if (going_dn) begin
            count  <= count - 1'b1;
            cnt_up <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/qc_hold_latch.sv
module qc_hold_latch #(
   parameter int W     = 16,
   parameter int BUS_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [W-1:0]     count,
   input  logic             sel_n,
   input  logic             oe_n,
   output logic [BUS_W-1:0] data_out,
   output logic [W-1:0]     hold,
   output logic             inhibit
);

   localparam int NB = W / BUS_W;

   if (NB != 2 || NB * BUS_W != W) begin : g_bad_split
      $error("holding register must split into exactly two bus bytes");
   end

   logic             lo_seen;
   logic [BUS_W-1:0] bytes [NB];

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold    <= '0;
         inhibit <= 1'b0;
         lo_seen <= 1'b0;
      end else if (inhibit) begin
         if (!oe_n && sel_n) lo_seen <= 1'b1;
         if (oe_n && lo_seen) begin
            inhibit <= 1'b0;
            lo_seen <= 1'b0;
            hold    <= count;
         end
      end else begin
         hold <= count;
         if (!oe_n && !sel_n) inhibit <= 1'b1;
      end
   end

   for (genvar g = 0; g < NB; g++) begin : g_byte
      assign bytes[g] = hold[g*BUS_W +: BUS_W];
   end

   assign data_out = oe_n ? '0 : (sel_n ? bytes[0] : bytes[NB-1]);

endmodule

// File: rtl/quad_cascade_counter.sv
module quad_cascade_counter
   import qc_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int BUS_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ch_a,
   input  logic             ch_b,
   input  logic             sel_n,
   input  logic             oe_n,
   output logic [BUS_W-1:0] data_out,
   output logic             cnt_pulse,
   output logic             cnt_up,
   output logic             cas_pulse
);

   if (CNT_W != 2 * BUS_W) begin : g_bad_width
      $error("CNT_W must be twice BUS_W");
   end

   logic [1:0]       ab_sync;
   qstep_e           step;
   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] hold_q;
   logic             inhibit_q;

   qc_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({ch_a, ch_b}), .q(ab_sync)
   );

   qc_decoder u_dec (
      .clk(clk), .rst_n(rst_n), .ab(ab_sync), .step(step)
   );

   qc_position #(.W(CNT_W)) u_pos (
      .clk(clk), .rst_n(rst_n), .step(step), .count(count_q),
      .cnt_pulse(cnt_pulse), .cnt_up(cnt_up), .cas_pulse(cas_pulse)
   );

   qc_hold_latch #(.W(CNT_W), .BUS_W(BUS_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .count(count_q), .sel_n(sel_n),
      .oe_n(oe_n), .data_out(data_out), .hold(hold_q), .inhibit(inhibit_q)
   );

endmodule

// File: rtl/qc_checker.sv
module qc_checker #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic [W-1:0] count,
   input logic [W-1:0] hold,
   input logic         inhibit,
   input logic         cnt_pulse,
   input logic         cnt_up,
   input logic         cas_pulse
);

   AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_pulse && cnt_up |-> count == W'($past(count) + 1'b1)); // R1
   AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_pulse && !cnt_up |-> count == W'($past(count) - 1'b1)); // R1
   AST_IDLE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_pulse |-> $stable(count)); // R5
   AST_WRAP_UP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      cas_pulse && cnt_up |-> count == '0); // R2
   AST_WRAP_DOWN_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      cas_pulse && !cnt_up |-> &count); // R2
   AST_CAS_WITH_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      cas_pulse |-> cnt_pulse); // R3
   AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      inhibit && $past(inhibit) |-> $stable(hold)); // R6

endmodule

bind quad_cascade_counter qc_checker #(.W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .count(count_q), .hold(hold_q),
   .inhibit(inhibit_q), .cnt_pulse(cnt_pulse), .cnt_up(cnt_up),
   .cas_pulse(cas_pulse)
);

// File: tb/quad_cascade_counter_bench.sv
module quad_cascade_counter_bench;

   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ch_a = 1'b0, ch_b = 1'b0;
   logic       sel_n = 1'b1, oe_n = 1'b1;
   logic [7:0] data_out;
   logic       cnt_pulse, cnt_up, cas_pulse;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   logic [15:0] pos = 16'h0000;
   logic [1:0]  phase = 2'd0;
   logic [1:0]  expq [$];

   always #(CLK_P/2) clk = ~clk;

   quad_cascade_counter u_quad_cascade_counter (
      .clk(clk), .rst_n(rst_n), .ch_a(ch_a), .ch_b(ch_b), .sel_n(sel_n),
      .oe_n(oe_n), .data_out(data_out), .cnt_pulse(cnt_pulse),
      .cnt_up(cnt_up), .cas_pulse(cas_pulse)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [1:0] ab_of(input logic [1:0] p);
      case (p)
         2'd0:    return 2'b00;
         2'd1:    return 2'b10;
         2'd2:    return 2'b11;
         default: return 2'b01;
      endcase
   endfunction

   // monitor: pops one expected {up,cas} item per observed pulse
   always @(negedge clk) begin
      if (rst_n && cnt_pulse) begin
         if (expq.size() == 0) begin
            chk(1'b0, "R5 unexpected pulse", 1, 0);
         end else begin
            logic [1:0] e;
            e = expq.pop_front();
            chk(cnt_up == e[1], "R4 direction", int'(cnt_up), int'(e[1]));
            chk(cas_pulse == e[0], "R3 cascade", int'(cas_pulse), int'(e[0]));
         end
      end else if (rst_n && cas_pulse) begin
         chk(1'b0, "R3 cascade without count", 1, 0);
      end
   end

   // push expectation, update model, drive the new code; returns after posedge+1
   task automatic launch_step(input bit up);
      logic       cas;
      logic [1:0] ab;
      cas = up ? (pos == 16'hFFFF) : (pos == 16'h0000);
      expq.push_back({up, cas});
      pos   = up ? pos + 16'd1 : pos - 16'd1;
      phase = up ? phase + 2'd1 : phase - 2'd1;
      ab    = ab_of(phase);
      @(posedge clk); #1;
      ch_a = ab[1];
      ch_b = ab[0];
   endtask

   task automatic do_step(input bit up);
      launch_step(up);
      @(posedge clk); @(posedge clk); @(negedge clk);
      chk(cnt_pulse == 1'b0, "R10 early pulse", int'(cnt_pulse), 0);
      @(posedge clk); @(negedge clk);
      chk(cnt_pulse == 1'b1, "R10 third-edge pulse", int'(cnt_pulse), 1);
   endtask

   task automatic read_begin(output logic [7:0] hi);
      @(posedge clk); #1;
      sel_n = 1'b0; oe_n = 1'b0;
      @(posedge clk); #2;
      hi = data_out;
   endtask

   task automatic read_end(output logic [7:0] lo);
      sel_n = 1'b1;
      @(posedge clk); #2;
      lo = data_out;
      oe_n = 1'b1;
      @(posedge clk); @(posedge clk);
   endtask

   task automatic read_pos(output logic [15:0] v);
      logic [7:0] h, l;
      read_begin(h);
      read_end(l);
      v = {h, l};
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      logic [7:0]  h, l;

      #(CLK_P * 3);
      @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      chk(cnt_pulse == 0 && cas_pulse == 0 && cnt_up == 0, "R9 reset outputs",
          {cnt_pulse, cas_pulse, cnt_up}, 0);
      read_pos(v);
      chk(v == 16'h0000, "R9 reset count", v, 0);

      // R1 R4: up steps
      for (int i = 0; i < 5; i++) do_step(1'b1);
      read_pos(v);
      chk(v == pos, "R1 count after up steps", v, pos);

      // R2 R3: down across zero
      for (int i = 0; i < 7; i++) do_step(1'b0);
      read_pos(v);
      chk(v == 16'hFFFE, "R2 down wrap", v, 16'hFFFE);

      // R2 R3: up across FFFF
      do_step(1'b1);
      do_step(1'b1);
      read_pos(v);
      chk(v == 16'h0000, "R2 up wrap", v, 0);

      // R5: double transition ignored
      @(posedge clk); #1;
      ch_a = ~ch_a; ch_b = ~ch_b;
      repeat (5) @(posedge clk);
      read_pos(v);
      chk(v == pos, "R5 count unchanged", v, pos);
      // return to the modelled phase with another double change
      @(posedge clk); #1;
      ch_a = ~ch_a; ch_b = ~ch_b;
      repeat (5) @(posedge clk);

      // R6 R7 R8: freeze during read while counting continues
      for (int i = 0; i < 3; i++) do_step(1'b1);
      read_begin(h);
      chk(h == 8'h00, "R7 high byte", h, 0);
      for (int i = 0; i < 4; i++) do_step(1'b1);
      @(posedge clk); #2;
      chk(data_out == 8'h00, "R6 high byte frozen", data_out, 0);
      read_end(l);
      chk(l == 8'h03, "R6 low byte frozen", l, 3);
      #2;
      chk(data_out == 8'h00, "R7 idle bus", data_out, 0);
      read_pos(v);
      chk(v == 16'h0007, "R8 tracks after release", v, 7);

      // R7: low byte without a read start shows tracking value
      sel_n = 1'b1; oe_n = 1'b0;
      @(posedge clk); #2;
      chk(data_out == 8'h07, "R7 low byte select", data_out, 7);
      oe_n = 1'b1;

      // bring position to FFFF
      for (int i = 0; i < 8; i++) do_step(1'b0);

      // read started one clock before the wrapping edge -> FFFF held
      launch_step(1'b1);
      @(posedge clk); #1;
      sel_n = 1'b0; oe_n = 1'b0;
      @(posedge clk); #2;
      h = data_out;
      @(posedge clk); @(posedge clk); #2;
      chk(h == 8'hFF && data_out == 8'hFF, "R6 pre-wrap capture", {h, data_out}, 16'hFFFF);
      read_end(l);
      chk(l == 8'hFF, "R6 pre-wrap low byte", l, 8'hFF);

      // back to FFFF, then read started right after the wrapping edge -> 0000
      do_step(1'b0);
      launch_step(1'b1);
      @(posedge clk); @(posedge clk); @(posedge clk); #1;
      sel_n = 1'b0; oe_n = 1'b0;
      @(posedge clk); #2;
      h = data_out;
      read_end(l);
      chk({h, l} == 16'h0000, "R3 wrap and read same cycle", {h, l}, 0);
      chk(expq.size() == 0, "R3 all pulses seen", expq.size(), 0);

      repeat (4) @(posedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule